// File: doc/BRIEF.md
# Memory-Mapped Bus Address Decoder

This block sits between a CPU with an 8-bit data bus and a 16-bit address bus and the targets that answer that bus: one RAM region, one ROM region and four I/O peripherals, all in a single shared 64 KiB space. For each valid bus cycle it asserts exactly one target enable and hands that target a local address with the region bits stripped off. Unused upper bits of the local address are zero.

Address bit 15 set selects ROM, which spans the upper half and so always holds the reset vector bytes at 0xFFFE and 0xFFFF. With bit 15 clear, bit 14 chooses between RAM (bit 14 clear, which covers the low working area 0x0000 to 0x01FF) and the I/O window (bit 14 set). Inside the I/O window, bits 13:12 pick one of four 4 KiB peripheral slots. Write strobes reach only RAM and the I/O slots. A write aimed at ROM reaches nobody and raises an error flag for one cycle.

Targets answer reads one cycle after the read is issued. The decoder remembers which target the read selected and, in the following cycle, steers that target's read data back to the CPU. This holds even while a new access to a different target is already being decoded.

Top module: `bus_addr_decoder`

## Requirements
- R1: With `bus_valid` high and address bits 15:14 equal to 00 (0x0000 to 0x3FFF, which includes 0x0000 to 0x01FF), only `ram_sel` is high and `tgt_addr` equals address bits 13:0, with `tgt_addr[14]` zero.
- R2: With `bus_valid` high and address bit 15 equal to 1 (0x8000 to 0xFFFF, which includes 0xFFFE and 0xFFFF), only `rom_sel` is high and `tgt_addr` equals address bits 14:0.
- R3: With `bus_valid` high and address bits 15:14 equal to 01 (0x4000 to 0x7FFF), only `io_sel[k]` is high, where k is the value of address bits 13:12. `tgt_addr` equals address bits 11:0, and `tgt_addr[14:12]` is zero.
- R4: While `bus_valid` is high, exactly one of the six enables {`io_sel[3:0]`, `rom_sel`, `ram_sel`} is high.
- R5: `ram_wr` is high exactly when `bus_valid`, `bus_write` and `ram_sel` are all high. `io_wr[k]` is high exactly when `bus_valid`, `bus_write` and `io_sel[k]` are all high. A write to ROM drives no strobe. `tgt_wdata` always equals `bus_wdata`.
- R6: `rom_wr_err` is high in the cycle after a valid write to a ROM address. In every other cycle, and during reset, it is low.
- R7: In the cycle after a valid read (`bus_valid` high, `bus_write` low), `bus_rdata` equals the present read-data input of the target that the read selected, whatever address is on the bus now.
- R8: In the cycle after any cycle without a valid read, including writes, idle cycles and reset, `bus_rdata` is zero.
- R9: While `bus_valid` is low, all enables and all write strobes are low and `tgt_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | CPU access in progress this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | CPU byte address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data steered back to the CPU |
| ram_sel | output | 1 | RAM enable |
| rom_sel | output | 1 | ROM enable |
| io_sel | output | 4 | Peripheral slot enables |
| tgt_addr | output | 15 | Local address for the selected target |
| tgt_wdata | output | 8 | Write data to targets |
| ram_wr | output | 1 | RAM write strobe |
| io_wr | output | 4 | Peripheral write strobes |
| ram_rdata | input | 8 | RAM read data, one cycle after the read |
| rom_rdata | input | 8 | ROM read data, one cycle after the read |
| io_rdata | input | 32 | Peripheral read data, slot k in bits 8k+7:8k |
| rom_wr_err | output | 1 | One-cycle flag for a write to ROM |

## Verification
Two functions can fall in the same cycle: the return of read data for the previous access, and the decode of a new access, which may itself be a ROM write raising the error flag a cycle later. The stimulus mixes reads and writes to different regions back to back and puts fresh random bytes on every read-data input each cycle. A steering error that followed the current address instead of the registered one therefore returns a visibly wrong byte. A behavioural model keeps its own pending-read target and judges every output in every cycle.

// File: rtl/busdec_pkg.sv
package busdec_pkg;
  localparam int ADDR_W  = 16;
  localparam int LOC_W   = ADDR_W - 1;
  localparam int NUM_IO  = 4;
  localparam int SLOT_W  = 12;
  localparam int NUM_TGT = 2 + NUM_IO;
  localparam int TGT_W   = $clog2(NUM_TGT);
  localparam int IDX_RAM = 0;
  localparam int IDX_ROM = 1;
  localparam int IDX_IO0 = 2;

  typedef enum logic [TGT_W-1:0] {
    T_RAM = TGT_W'(IDX_RAM),
    T_ROM = TGT_W'(IDX_ROM),
    T_IO0 = TGT_W'(IDX_IO0),
    T_IO1 = TGT_W'(IDX_IO0 + 1),
    T_IO2 = TGT_W'(IDX_IO0 + 2),
    T_IO3 = TGT_W'(IDX_IO0 + 3)
  } tgt_e;

  // Region of an address: bit 15 wins, then bit 14, then the slot bits 13:12.
  function automatic tgt_e region_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1])       return T_ROM;
    if (!a[ADDR_W-2])      return T_RAM;
    return tgt_e'(TGT_W'(IDX_IO0) + TGT_W'(a[SLOT_W+1:SLOT_W]));
  endfunction

  // Local address seen by the target, with the region bits cleared.
  function automatic logic [LOC_W-1:0] local_of(input logic [ADDR_W-1:0] a);
    logic [LOC_W-1:0] r;
    unique case (region_of(a))
      T_ROM:   r = a[LOC_W-1:0];
      T_RAM:   r = {1'b0, a[LOC_W-2:0]};
      default: r = {{(LOC_W-SLOT_W){1'b0}}, a[SLOT_W-1:0]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/busdec_addr_decode.sv
module busdec_addr_decode
  import busdec_pkg::*;
(
  input  logic               valid,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_TGT-1:0] sel,
  output logic [LOC_W-1:0]   loc,
  output tgt_e               tgt
);
  assign tgt = region_of(addr);
  assign loc = valid ? local_of(addr) : '0;

  for (genvar i = 0; i < NUM_TGT; i++) begin : g_sel
    assign sel[i] = valid && (tgt == tgt_e'(TGT_W'(i)));
  end
endmodule

// File: rtl/busdec_wr_gate.sv
module busdec_wr_gate
  import busdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               write,
  input  logic [NUM_TGT-1:0] sel,
  output logic               ram_wr,
  output logic [NUM_IO-1:0]  io_wr,
  output logic               rom_hit,
  output logic               rom_err
);
  assign ram_wr  = write && sel[IDX_RAM];
  assign rom_hit = write && sel[IDX_ROM];

  for (genvar k = 0; k < NUM_IO; k++) begin : g_io_wr
    assign io_wr[k] = write && sel[IDX_IO0 + k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rom_err <= 1'b0;
    else        rom_err <= rom_hit;
  end
endmodule

// File: rtl/busdec_rd_steer.sv
module busdec_rd_steer
  import busdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_issue,
  input  tgt_e                     rd_tgt,
  input  logic [DATA_W-1:0]        ram_rdata,
  input  logic [DATA_W-1:0]        rom_rdata,
  input  logic [NUM_IO*DATA_W-1:0] io_rdata,
  output logic                     rd_return,
  output logic [DATA_W-1:0]        rdata
);
  localparam int SRC_N = 1 << TGT_W;

  logic [DATA_W-1:0] src [SRC_N];
  tgt_e              pend_tgt;

  assign src[IDX_RAM] = ram_rdata;
  assign src[IDX_ROM] = rom_rdata;
  for (genvar k = 0; k < NUM_IO; k++) begin : g_io_src
    assign src[IDX_IO0 + k] = io_rdata[k*DATA_W +: DATA_W];
  end
  for (genvar j = NUM_TGT; j < SRC_N; j++) begin : g_pad_src
    assign src[j] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_return <= 1'b0;
      pend_tgt  <= T_RAM;
    end else begin
      rd_return <= rd_issue;
      if (rd_issue) pend_tgt <= rd_tgt;
    end
  end

  assign rdata = rd_return ? src[pend_tgt] : '0;
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import busdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     ram_sel,
  output logic                     rom_sel,
  output logic [NUM_IO-1:0]        io_sel,
  output logic [LOC_W-1:0]         tgt_addr,
  output logic [DATA_W-1:0]        tgt_wdata,
  output logic                     ram_wr,
  output logic [NUM_IO-1:0]        io_wr,
  input  logic [DATA_W-1:0]        ram_rdata,
  input  logic [DATA_W-1:0]        rom_rdata,
  input  logic [NUM_IO*DATA_W-1:0] io_rdata,
  output logic                     rom_wr_err
);
  logic [NUM_TGT-1:0] sel_vec;
  tgt_e               cur_tgt;
  logic               rd_issue;
  logic               rd_return;
  logic               rom_hit;

  assign rd_issue  = bus_valid && !bus_write;
  assign tgt_wdata = bus_wdata;
  assign ram_sel   = sel_vec[IDX_RAM];
  assign rom_sel   = sel_vec[IDX_ROM];
  assign io_sel    = sel_vec[IDX_IO0 +: NUM_IO];

  busdec_addr_decode u_dec (
    .valid (bus_valid),
    .addr  (bus_addr),
    .sel   (sel_vec),
    .loc   (tgt_addr),
    .tgt   (cur_tgt)
  );

  busdec_wr_gate u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .write   (bus_write),
    .sel     (sel_vec),
    .ram_wr  (ram_wr),
    .io_wr   (io_wr),
    .rom_hit (rom_hit),
    .rom_err (rom_wr_err)
  );

  busdec_rd_steer #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (rd_issue),
    .rd_tgt    (cur_tgt),
    .ram_rdata (ram_rdata),
    .rom_rdata (rom_rdata),
    .io_rdata  (io_rdata),
    .rd_return (rd_return),
    .rdata     (bus_rdata)
  );
endmodule

// File: rtl/busdec_chk.sv
module busdec_chk
  import busdec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_valid,
  input logic                     bus_write,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_TGT-1:0]       sel_vec,
  input logic                     ram_sel,
  input logic                     rom_sel,
  input logic [NUM_IO-1:0]        io_sel,
  input logic [LOC_W-1:0]         tgt_addr,
  input logic                     ram_wr,
  input logic [NUM_IO-1:0]        io_wr,
  input logic [DATA_W-1:0]        ram_rdata,
  input logic [DATA_W-1:0]        rom_rdata,
  input logic                     rd_return,
  input logic                     rom_wr_err
);
  // R1
  ram_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[15:14] == 2'b00) |-> (ram_sel && tgt_addr == {1'b0, bus_addr[13:0]}));
  // R2
  rom_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[15]) |-> (rom_sel && tgt_addr == bus_addr[14:0]));
  // R3
  io_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[15:14] == 2'b01) |->
      (io_sel == (4'b0001 << bus_addr[13:12]) && tgt_addr == {3'b000, bus_addr[11:0]}));
  // R4
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $countones(sel_vec) == 1);
  // R5
  rom_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[15]) |-> (!ram_wr && io_wr == '0));
  // R6
  rom_err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr[15]) |=> rom_wr_err);
  // R6
  rom_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr[15]) |=> !rom_wr_err);
  // R7
  rom_read_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[15]) |=> (rd_return && bus_rdata == rom_rdata));
  // R7
  ram_read_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[15:14] == 2'b00) |=> bus_rdata == ram_rdata);
  // R8
  no_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> bus_rdata == '0);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (sel_vec == '0 && tgt_addr == '0 && !ram_wr && io_wr == '0));
endmodule

bind bus_addr_decoder busdec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .sel_vec    (sel_vec),
  .ram_sel    (ram_sel),
  .rom_sel    (rom_sel),
  .io_sel     (io_sel),
  .tgt_addr   (tgt_addr),
  .ram_wr     (ram_wr),
  .io_wr      (io_wr),
  .ram_rdata  (ram_rdata),
  .rom_rdata  (rom_rdata),
  .rd_return  (rd_return),
  .rom_wr_err (rom_wr_err)
);

// File: tb/sim_bus_addr_decoder.sv
`timescale 1ns/1ps
module sim_bus_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        ram_sel, rom_sel;
  logic [3:0]  io_sel;
  logic [14:0] tgt_addr;
  logic [7:0]  tgt_wdata;
  logic        ram_wr;
  logic [3:0]  io_wr;
  logic [7:0]  ram_rdata, rom_rdata;
  logic [31:0] io_rdata;
  logic        rom_wr_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  bit exp_pend = 0;
  int exp_pend_tgt = 0;
  bit exp_err = 0;

  always #2 clk = ~clk;

  bus_addr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .io_sel(io_sel), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .ram_wr(ram_wr), .io_wr(io_wr),
    .ram_rdata(ram_rdata), .rom_rdata(rom_rdata), .io_rdata(io_rdata),
    .rom_wr_err(rom_wr_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Byte a target presents now; target index 0 RAM, 1 ROM, 2..5 IO slots.
  function automatic int src_byte(input int t);
    if (t == 0) return int'(ram_rdata);
    if (t == 1) return int'(rom_rdata);
    return int'((io_rdata >> (8 * (t - 2))) & 32'hFF);
  endfunction

  task automatic step(input logic [15:0] a, input bit v, input bit w);
    int ai, t, loc, exp_sel, exp_ioe;
    string tag;
    @(negedge clk);
    bus_addr  = a;
    bus_valid = v;
    bus_write = w;
    bus_wdata = 8'($urandom);
    ram_rdata = 8'($urandom);
    rom_rdata = 8'($urandom);
    io_rdata  = $urandom;
    #1;
    ai = int'(a);
    if (ai >= 32768)      begin t = 1; loc = ai - 32768; end
    else if (ai < 16384)  begin t = 0; loc = ai; end
    else                  begin t = 2 + (ai - 16384) / 4096; loc = ai % 4096; end
    if (!v)          tag = "R9";
    else if (t == 0) tag = "R1";
    else if (t == 1) tag = "R2";
    else             tag = "R3";
    exp_sel = v ? (1 << t) : 0;
    chk(tag, int'({io_sel, rom_sel, ram_sel}), exp_sel);
    if (v) chk("R4", $countones({io_sel, rom_sel, ram_sel}), 1);
    chk(tag, int'(tgt_addr), v ? loc : 0);
    exp_ioe = (v && w && t >= 2) ? (1 << (t - 2)) : 0;
    chk("R5", int'(ram_wr), (v && w && t == 0) ? 1 : 0);
    chk("R5", int'(io_wr), exp_ioe);
    chk("R5", int'(tgt_wdata), int'(bus_wdata));
    chk("R6", int'(rom_wr_err), int'(exp_err));
    if (exp_pend) chk("R7", int'(bus_rdata), src_byte(exp_pend_tgt));
    else          chk("R8", int'(bus_rdata), 0);
    exp_err  = v && w && (t == 1);
    exp_pend = v && !w;
    if (exp_pend) exp_pend_tgt = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] dir [12];
    rst_n = 1'b0; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    ram_rdata = 8'h5A; rom_rdata = 8'hA5; io_rdata = 32'h11223344;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", int'(bus_rdata), 0);
    chk("R6", int'(rom_wr_err), 0);
    chk("R9", int'({io_sel, rom_sel, ram_sel}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    dir = '{16'h0000, 16'h01FF, 16'h3FFF, 16'h4000, 16'h4FFF, 16'h5000,
            16'h6ABC, 16'h7FFF, 16'h8000, 16'hC123, 16'hFFFE, 16'hFFFF};
    // R1 R2 R3 boundaries: read each, then write each
    foreach (dir[i]) step(dir[i], 1, 0);
    foreach (dir[i]) step(dir[i], 1, 1);
    // R6: back-to-back ROM writes, then a quiet cycle
    step(16'hFFFE, 1, 1); step(16'h9000, 1, 1); step(16'h0000, 0, 1);
    // R7: read ROM while a RAM write is decoded, read IO then ROM write
    step(16'hFFFF, 1, 0); step(16'h0100, 1, 1);
    step(16'h7001, 1, 0); step(16'hFFFE, 1, 1); step(16'h0000, 0, 0);
    // R8: invalid read does not return data
    step(16'h8000, 0, 0); step(16'h8000, 0, 0);
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ra;
      ra = 16'($urandom);
      if ((n % 7) == 0) ra[15] = 1'b1;
      step(ra, ($urandom % 5) != 0, ($urandom % 2) == 1);
    end
    step(16'h0000, 0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule